// File: doc/BRIEF.md
# Burst-Aware Digital Power-Down Controller

This controller decides when the registers of a transmit signal chain may have their clock turned off, and when the analog section may be shut down. Power-down can be requested in three ways. A hardware pin requests it directly. A full-sleep control bit requests a deeper power-down. With the automatic mode enabled, the end of a transmit burst requests it. In every case the block first asks the datapath to drain, then waits a fixed number of cycles equal to the pipeline depth. Only after that wait does it drop the datapath clock enable.

When transmit-enable rises, the clock enable is restored on the next edge. On a release of the hardware pin, the datapath restarts. After full sleep ends, the block keeps its ready flag low until the PLL reports lock. The output data clock and the register file sit outside this block and are never gated by it. All outputs come straight from flops, so the gated domain only sees enable changes at clock edges.

Top module: `pwr_dn_ctrl`

## Requirements
- R1: After reset the outputs are clk_en=1, flush=0, analog_off=0 and ready=1 (the run state).
- R2: In the run state, hw_pd_i=1 makes flush_req_o=1 and ready_o=0 from the next edge. dp_clk_en_o stays 1 for exactly FLUSH_CYCLES cycles. After that, dp_clk_en_o and flush_req_o both read 0.
- R3: In the gated state, hw_pd_i=0 gives dp_clk_en_o=1 and ready_o=1 after the next edge, including when tx_en_i rises in the same cycle. Releasing hw_pd_i during a hardware flush also returns to run on the next edge.
- R4: With auto_pd_en_i=1, a 1-to-0 change of tx_en_i starts a FLUSH_CYCLES-long flush that ends with the clock gated. With auto_pd_en_i=0, the same edge has no effect on any output.
- R5: In the auto-gated state, tx_en_i=1 makes dp_clk_en_o=1 and ready_o=1 after the next edge.
- R6: If tx_en_i returns high during an automatic flush, the flush ends and the block is back in run on the next edge. A later falling edge starts a fresh flush of the full FLUSH_CYCLES length.
- R7: full_sleep_i=1 starts a flush of FLUSH_CYCLES cycles. It then gives analog_off_o=1 with dp_clk_en_o=0 and ready_o=0.
- R8: When full_sleep_i returns to 0, analog_off_o clears on the next edge. ready_o and dp_clk_en_o stay 0 while pll_lock_i is 0. They rise on the edge after pll_lock_i is seen high.
- R9: Priority is full sleep, then the hardware pin, then the automatic mode. Sleep wins over hw_pd_i, both at flush end and from the gated state. While hw_pd_i is held, tx_en_i=1 neither stops the flush nor ungates the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_pd_i | input | 1 | Hardware power-down request, active high |
| tx_en_i | input | 1 | Transmit enable; high during a burst |
| auto_pd_en_i | input | 1 | Control bit: enable power-down between bursts |
| full_sleep_i | input | 1 | Control bit: request full sleep |
| pll_lock_i | input | 1 | PLL lock indicator |
| dp_clk_en_o | output | 1 | Registered clock enable for datapath registers |
| flush_req_o | output | 1 | Asks the datapath to drain its pipeline |
| analog_off_o | output | 1 | Shuts down the analog section |
| ready_o | output | 1 | High when the datapath is running and usable |

## Verification
The hardest situation to reach is a burst that resumes inside an automatic flush and then ends again. The stimulus drops tx_en_i with auto mode on and lets a few flush cycles pass. It raises tx_en_i for one cycle and drops it again. The full flush length is then counted from the second edge to show that the timer restarted. A second hard case is leaving sleep with the PLL unlocked. The bench pulls pll_lock_i low while asleep, releases sleep, holds the lock low for several cycles to see that ready stays down, and only then asserts lock.

// File: rtl/pd_pkg.sv
package pd_pkg;

    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_FLUSH     = 3'd1,
        ST_GATED     = 3'd2,
        ST_SLEEP     = 3'd3,
        ST_WAIT_LOCK = 3'd4
    } pd_state_e;

    typedef struct packed {
        pd_state_e st;
        logic      auto_src;
        logic      clk_en;
        logic      flush;
        logic      aoff;
        logic      rdy;
    } pd_regs_t;

endpackage

// File: rtl/pd_txen_edge.sv
module pd_txen_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en_i,
    output logic fall_o
);
    logic tx_d, tx_q;

    always_comb begin
        tx_d = tx_en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= 1'b0;
        else        tx_q <= tx_d;
    end

    assign fall_o = tx_q & ~tx_en_i;

endmodule

// File: rtl/pd_flush_timer.sv
module pd_flush_timer #(
    parameter int FLUSH_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic done_o
);
    localparam int CNT_W = (FLUSH_CYCLES > 1) ? $clog2(FLUSH_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(FLUSH_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = LOAD_VAL;
        else if (run_i && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = run_i && (cnt_q == '0);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) < FLUSH_CYCLES);

    // R2
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == LOAD_VAL));

endmodule

// File: rtl/pd_fsm.sv
module pd_fsm
    import pd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hw_pd_i,
    input  logic tx_en_i,
    input  logic tx_fall_i,
    input  logic auto_pd_en_i,
    input  logic full_sleep_i,
    input  logic pll_lock_i,
    input  logic flush_done_i,
    output logic flush_load_o,
    output logic flush_run_o,
    output logic clk_en_o,
    output logic flush_o,
    output logic aoff_o,
    output logic rdy_o
);
    pd_regs_t r_d, r_q;
    logic     hold;

    always_comb begin
        r_d  = r_q;
        hold = full_sleep_i | hw_pd_i |
               (r_q.auto_src & auto_pd_en_i & ~tx_en_i);

        unique case (r_q.st)
            ST_RUN: begin
                if (full_sleep_i || hw_pd_i) begin
                    r_d.st       = ST_FLUSH;
                    r_d.auto_src = 1'b0;
                end else if (auto_pd_en_i && tx_fall_i) begin
                    r_d.st       = ST_FLUSH;
                    r_d.auto_src = 1'b1;
                end
            end
            ST_FLUSH: begin
                if (!hold)
                    r_d.st = ST_RUN;
                else if (flush_done_i)
                    r_d.st = full_sleep_i ? ST_SLEEP : ST_GATED;
            end
            ST_GATED: begin
                if (full_sleep_i)
                    r_d.st = ST_SLEEP;
                else if (!hold)
                    r_d.st = ST_RUN;
            end
            ST_SLEEP: begin
                if (!full_sleep_i)
                    r_d.st = ST_WAIT_LOCK;
            end
            ST_WAIT_LOCK: begin
                if (full_sleep_i)
                    r_d.st = ST_SLEEP;
                else if (pll_lock_i)
                    r_d.st = ST_RUN;
            end
            default: r_d.st = ST_RUN;
        endcase

        r_d.clk_en = (r_d.st == ST_RUN) || (r_d.st == ST_FLUSH);
        r_d.flush  = (r_d.st == ST_FLUSH);
        r_d.aoff   = (r_d.st == ST_SLEEP);
        r_d.rdy    = (r_d.st == ST_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= ST_RUN;
            r_q.auto_src <= 1'b0;
            r_q.clk_en   <= 1'b1;
            r_q.flush    <= 1'b0;
            r_q.aoff     <= 1'b0;
            r_q.rdy      <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign flush_load_o = (r_d.st == ST_FLUSH) && (r_q.st != ST_FLUSH);
    assign flush_run_o  = (r_q.st == ST_FLUSH);
    assign clk_en_o     = r_q.clk_en;
    assign flush_o      = r_q.flush;
    assign aoff_o       = r_q.aoff;
    assign rdy_o        = r_q.rdy;

    // R8
    lock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT_LOCK && !pll_lock_i) |=> !rdy_o);

    // R5
    burst_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_GATED && tx_en_i && !hw_pd_i && !full_sleep_i) |=> clk_en_o);

    // R9
    hw_over_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_GATED && hw_pd_i) |=> !clk_en_o);

endmodule

// File: rtl/pwr_dn_ctrl.sv
module pwr_dn_ctrl #(
    parameter int FLUSH_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_pd_i,
    input  logic tx_en_i,
    input  logic auto_pd_en_i,
    input  logic full_sleep_i,
    input  logic pll_lock_i,
    output logic dp_clk_en_o,
    output logic flush_req_o,
    output logic analog_off_o,
    output logic ready_o
);
    logic tx_fall, fl_load, fl_run, fl_done;

    pd_txen_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_en_i (tx_en_i),
        .fall_o  (tx_fall)
    );

    pd_flush_timer #(.FLUSH_CYCLES(FLUSH_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (fl_load),
        .run_i  (fl_run),
        .done_o (fl_done)
    );

    pd_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .hw_pd_i      (hw_pd_i),
        .tx_en_i      (tx_en_i),
        .tx_fall_i    (tx_fall),
        .auto_pd_en_i (auto_pd_en_i),
        .full_sleep_i (full_sleep_i),
        .pll_lock_i   (pll_lock_i),
        .flush_done_i (fl_done),
        .flush_load_o (fl_load),
        .flush_run_o  (fl_run),
        .clk_en_o     (dp_clk_en_o),
        .flush_o      (flush_req_o),
        .aoff_o       (analog_off_o),
        .rdy_o        (ready_o)
    );

    // R2
    no_abrupt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dp_clk_en_o) |-> $past(flush_req_o));

    // R2
    hw_starts_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && hw_pd_i) |=> flush_req_o);

    // R7
    sleep_digital_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        analog_off_o |-> (!dp_clk_en_o && !ready_o));

endmodule

// File: tb/tb_pwr_dn_ctrl.sv
module tb_pwr_dn_ctrl;
    localparam int FL = 16;

    typedef struct {
        int         cyc;
        string      tag;
        logic [3:0] v;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hw_pd = 1'b0, tx_en = 1'b0, auto_en = 1'b0, sleep = 1'b0, lock = 1'b1;
    logic clk_en, flush, aoff, rdy;

    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    pwr_dn_ctrl #(.FLUSH_CYCLES(FL)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .hw_pd_i      (hw_pd),
        .tx_en_i      (tx_en),
        .auto_pd_en_i (auto_en),
        .full_sleep_i (sleep),
        .pll_lock_i   (lock),
        .dp_clk_en_o  (clk_en),
        .flush_req_o  (flush),
        .analog_off_o (aoff),
        .ready_o      (rdy)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pop and compare expectations on the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if ({clk_en, flush, aoff, rdy} !== e.v) begin
                failures++;
                $display("FAIL %s cyc=%0d actual{en,fl,aoff,rdy}=%b expected=%b",
                         e.tag, cyc, {clk_en, flush, aoff, rdy}, e.v);
            end
        end
    end

    task automatic expect_at(input int d, input string tag, input logic [3:0] v);
        exp_t e;
        e.cyc = cyc + d;
        e.tag = tag;
        e.v   = v;
        sb.push_back(e);
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
        tick(1);
    endtask

    localparam logic [3:0] RUN   = 4'b1001;
    localparam logic [3:0] FLSH  = 4'b1100;
    localparam logic [3:0] GATE  = 4'b0000;
    localparam logic [3:0] SLP   = 4'b0010;

    initial begin
        tick(3);
        rst_n = 1'b1;
        expect_at(0, "R1 reset state", RUN);
        drain();

        // R2: hardware power-down, timed flush then gate
        hw_pd = 1'b1;
        expect_at(1, "R2 flush starts", FLSH);
        expect_at(FL, "R2 still flushing at end", FLSH);
        expect_at(FL + 1, "R2 gated after flush", GATE);
        drain();

        // R3: release together with tx_en rising
        hw_pd = 1'b0; tx_en = 1'b1;
        expect_at(1, "R3 restart same cycle as tx_en", RUN);
        drain();

        // R4: auto disabled, falling edge ignored
        tx_en = 1'b0;
        expect_at(1, "R4 auto off no effect", RUN);
        expect_at(3, "R4 auto off still run", RUN);
        drain();
        tx_en = 1'b1;
        tick(2);

        // R4: auto enabled, falling edge flushes and gates
        auto_en = 1'b1; tx_en = 1'b0;
        expect_at(1, "R4 auto flush", FLSH);
        expect_at(FL, "R4 auto flush length", FLSH);
        expect_at(FL + 1, "R4 auto gated", GATE);
        drain();

        // R5: burst restarts clocks at once
        tx_en = 1'b1;
        expect_at(1, "R5 wake on tx_en", RUN);
        drain();

        // R6: burst resumes mid-flush, then ends again
        tx_en = 1'b0;
        expect_at(1, "R6 first flush", FLSH);
        drain();
        tick(3);
        tx_en = 1'b1;
        expect_at(1, "R6 abort to run", RUN);
        drain();
        tx_en = 1'b0;
        expect_at(1, "R6 second flush", FLSH);
        expect_at(FL, "R6 full length restarted", FLSH);
        expect_at(FL + 1, "R6 gated", GATE);
        drain();
        tx_en = 1'b1;
        tick(2);

        // R3: release during a hardware flush
        auto_en = 1'b0; hw_pd = 1'b1;
        expect_at(1, "R3 hw flush", FLSH);
        drain();
        tick(2);
        hw_pd = 1'b0;
        expect_at(1, "R3 release mid flush", RUN);
        drain();

        // R9: hw pin overrides tx_en high
        hw_pd = 1'b1;
        expect_at(1, "R9 hw flush with tx high", FLSH);
        expect_at(FL + 1, "R9 gated despite tx high", GATE);
        expect_at(FL + 3, "R9 stays gated", GATE);
        drain();

        // R9/R7: sleep from gated beats hw pin
        sleep = 1'b1;
        expect_at(1, "R9 sleep over hw gated", SLP);
        drain();
        hw_pd = 1'b0; lock = 1'b0;
        expect_at(2, "R7 sleep held", SLP);
        drain();

        // R8: leave sleep without lock
        sleep = 1'b0;
        expect_at(1, "R8 waiting for lock", GATE);
        expect_at(4, "R8 ready low without lock", GATE);
        drain();
        lock = 1'b1;
        expect_at(1, "R8 ready after lock", RUN);
        drain();

        // R7/R9: sleep and hw together from run
        auto_en = 1'b1; sleep = 1'b1; hw_pd = 1'b1;
        expect_at(1, "R7 sleep flush", FLSH);
        expect_at(FL, "R7 sleep flush length", FLSH);
        expect_at(FL + 1, "R9 sleep wins at flush end", SLP);
        drain();
        sleep = 1'b0; hw_pd = 1'b0;
        expect_at(1, "R8 analog back on", GATE);
        expect_at(2, "R8 run with lock held", RUN);
        drain();

        tick(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule